// File: doc/BRIEF.md
# Multiplexed Bus Register Interface with Transfer Commands

This block is the host-facing side of a real-time clock that sits on an 8-bit bus carrying both addresses and data. A select line marks each bus byte as an address or as data. Address bytes fill an internal pointer. Data bytes read or write the register space at that pointer. The space holds three status bytes, a trim byte, visible copies of the time, alarm and timer values, and sixteen bytes of general RAM.

The running time and the running timer are kept in a hidden area that the host cannot address. Here that area is a plain register array; nothing in this block counts. Three command addresses move whole snapshots between the hidden area and the visible copies in one step. After a command address has been latched, the direction of the next data access sets the direction of the copy. A lock bit protects the hidden area and the trim byte from host writes. A power-fail input isolates the block from the bus completely.

The block works with two strobe styles, chosen by a static input. One style uses separate read and write strobes. The other uses a data strobe together with a read/not-write level.

Top module: `rtcbus_host_if`

## Requirements
- R1: With `ad_sel` = 0, a write access loads `ad_in` into the address pointer. With `ad_sel` = 1, an access reads or writes the register at the pointer.
- R2: A read access with `ad_sel` = 0 returns the address pointer on `ad_out`. It reads 00 after reset.
- R3: The pointer keeps its value across any number of data accesses. It changes only when a new address is written.
- R4: After 0xF1 (clock), 0xF2 (timer) or 0xF0 (both) has been latched, a data read copies the selected hidden bytes into the visible bytes and a data write copies the visible bytes into the hidden ones. The byte read during such an access is 00, and the data written is discarded. Sets that were not selected keep their values.
- R5: These addresses read back what was last written to them: status bytes 0x00–0x02, trim 0x10, clock 0x20–0x28, alarm 0x30–0x34, timer 0x40–0x43 and general RAM 0x50–0x5F. Every byte is 00 after reset.
- R6: Any other address reads as 00 and ignores writes.
- R7: While status-0 bit 5 (lock) is 1, write-direction copies and writes to the trim byte have no effect. Read-direction copies, general RAM and the status bytes stay fully usable.
- R8: A write of 0 to status-2 bit 4, made while that bit holds 1, sets status 0 to 0x01 (bit 0 is tuning mode), clears status 1 and status 2, and so releases the lock. A write of 0 to that bit while it already holds 0 changes nothing beyond the written byte.
- R9: While `pwr_ok` = 0, `ad_oe` stays 0 and no strobe has any effect, neither on the registers nor on the pointer.
- R10: `ad_oe` is 1 only during a read access: chip select low, the read condition of the selected strobe style met, and `pwr_ok` = 1. At all other times `ad_out` is 00.
- R11: With `bus_mode` = 0, `rd_n` and `wr_n` are separate active-low strobes. With `bus_mode` = 1, `rd_n` is an active-low data strobe and `wr_n` is a read/not-write level (1 = read).
- R12: An access acts once, at the first clock edge at which it is seen. Holding the strobe active for longer has no further effect, even if `ad_in` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | 0 isolates the block from the bus (power fail) |
| bus_mode | input | 1 | Strobe style: 0 separate read/write, 1 data strobe with read/not-write |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Read strobe, or data strobe when `bus_mode` = 1 |
| wr_n | input | 1 | Write strobe, or read/not-write level when `bus_mode` = 1 |
| ad_sel | input | 1 | 0 = bus byte is an address, 1 = bus byte is data |
| ad_in | input | 8 | Byte from host |
| ad_out | output | 8 | Byte to host |
| ad_oe | output | 1 | Host bus driver enable |

## Verification
The hardest state to reach is the hidden area, which has no port of its own. The only way to observe it is a round trip. The bench writes the visible copies, copies them down with one command, overwrites the visible copies, and then copies back up with another command before reading. Mixing the three commands in these round trips shows which byte sets each one touches. Repeating the round trip with the lock set, then after the tuning-mode initialisation sequence, shows that the lock blocks only the downward copy and trim writes.

// File: rtl/rtcbus_pkg.sv
package rtcbus_pkg;
  localparam int BYTE_W = 8;
  localparam int CLK_N  = 9;
  localparam int ALM_N  = 5;
  localparam int TMR_N  = 4;
  localparam int USR_N  = 16;
  localparam int CI_W   = $clog2(CLK_N);
  localparam int AI_W   = $clog2(ALM_N);
  localparam int TI_W   = $clog2(TMR_N);
  localparam int UI_W   = $clog2(USR_N);

  localparam logic [BYTE_W-1:0] A_ST0    = 8'h00;
  localparam logic [BYTE_W-1:0] A_ST1    = 8'h01;
  localparam logic [BYTE_W-1:0] A_ST2    = 8'h02;
  localparam logic [BYTE_W-1:0] A_TRIM   = 8'h10;
  localparam logic [BYTE_W-1:0] A_CLK    = 8'h20;
  localparam logic [BYTE_W-1:0] A_ALM    = 8'h30;
  localparam logic [BYTE_W-1:0] A_TMR    = 8'h40;
  localparam logic [BYTE_W-1:0] A_USR    = 8'h50;
  localparam logic [BYTE_W-1:0] A_CMD_AB = 8'hF0;
  localparam logic [BYTE_W-1:0] A_CMD_CK = 8'hF1;
  localparam logic [BYTE_W-1:0] A_CMD_TM = 8'hF2;

  localparam int LOCK_BIT = 5;
  localparam int INIT_BIT = 4;
  localparam logic [BYTE_W-1:0] ST0_AFTER_INIT = 8'h01;

  typedef enum logic [3:0] {
    RG_NONE, RG_ST0, RG_ST1, RG_ST2, RG_TRIM,
    RG_CLK, RG_ALM, RG_TMR, RG_USR, RG_CMD
  } region_e;

  function automatic logic in_span(input logic [BYTE_W-1:0] a,
                                   input logic [BYTE_W-1:0] base,
                                   input int n);
    return (a >= base) && (a < base + BYTE_W'(n));
  endfunction

  function automatic region_e region_of(input logic [BYTE_W-1:0] a);
    if (a == A_ST0)                   return RG_ST0;
    else if (a == A_ST1)              return RG_ST1;
    else if (a == A_ST2)              return RG_ST2;
    else if (a == A_TRIM)             return RG_TRIM;
    else if (in_span(a, A_CLK, CLK_N)) return RG_CLK;
    else if (in_span(a, A_ALM, ALM_N)) return RG_ALM;
    else if (in_span(a, A_TMR, TMR_N)) return RG_TMR;
    else if (in_span(a, A_USR, USR_N)) return RG_USR;
    else if (a == A_CMD_AB || a == A_CMD_CK || a == A_CMD_TM) return RG_CMD;
    else                              return RG_NONE;
  endfunction

  function automatic logic cmd_takes_clock(input logic [BYTE_W-1:0] a);
    return (a == A_CMD_AB) || (a == A_CMD_CK);
  endfunction

  function automatic logic cmd_takes_timer(input logic [BYTE_W-1:0] a);
    return (a == A_CMD_AB) || (a == A_CMD_TM);
  endfunction
endpackage

// File: rtl/rtcbus_strobe.sv
module rtcbus_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic bus_mode,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_act,
  output logic rd_pulse,
  output logic wr_pulse
);
  logic sel, wr_act, rd_q, wr_q;

  assign sel = pwr_ok && !cs_n;

  // style 0: two strobes; style 1: rd_n is the data strobe, wr_n is read/not-write
  always_comb begin
    if (bus_mode) begin
      rd_act = sel && !rd_n && wr_n;
      wr_act = sel && !rd_n && !wr_n;
    end else begin
      rd_act = sel && !rd_n && wr_n;
      wr_act = sel && !wr_n && rd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
    end
  end

  assign rd_pulse = rd_act && !rd_q;
  assign wr_pulse = wr_act && !wr_q;

  a_r12_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  a_r12_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |=> !rd_pulse);
  a_r9_pf_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (!rd_act && !wr_pulse));
endmodule

// File: rtl/rtcbus_regfile.sv
module rtcbus_regfile
  import rtcbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] addr,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] st0, st1, st2, trim;
  logic [BYTE_W-1:0] clk_v [CLK_N];
  logic [BYTE_W-1:0] clk_h [CLK_N];
  logic [BYTE_W-1:0] alm_v [ALM_N];
  logic [BYTE_W-1:0] tmr_v [TMR_N];
  logic [BYTE_W-1:0] tmr_h [TMR_N];
  logic [BYTE_W-1:0] usr_v [USR_N];

  region_e rg;
  logic [3:0] idx;
  logic locked, sel_clk, sel_tmr;
  // named internal events
  logic xfer_up, xfer_down, init_fire, trim_blocked;

  assign rg        = region_of(addr);
  assign idx       = addr[3:0];
  assign locked    = st0[LOCK_BIT];
  assign sel_clk   = cmd_takes_clock(addr);
  assign sel_tmr   = cmd_takes_timer(addr);
  assign xfer_up   = data_rd && (rg == RG_CMD);
  assign xfer_down = data_wr && (rg == RG_CMD) && !locked;
  assign init_fire = data_wr && (rg == RG_ST2) && st2[INIT_BIT] && !wdata[INIT_BIT];
  assign trim_blocked = data_wr && (rg == RG_TRIM) && locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st0 <= '0; st1 <= '0; st2 <= '0; trim <= '0;
    end else if (init_fire) begin
      st0 <= ST0_AFTER_INIT;
      st1 <= '0;
      st2 <= '0;
    end else if (data_wr) begin
      case (rg)
        RG_ST0:  st0 <= wdata;
        RG_ST1:  st1 <= wdata;
        RG_ST2:  st2 <= wdata;
        RG_TRIM: if (!locked) trim <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CLK_N; i++) begin clk_v[i] <= '0; clk_h[i] <= '0; end
      for (int i = 0; i < TMR_N; i++) begin tmr_v[i] <= '0; tmr_h[i] <= '0; end
    end else begin
      if (data_wr && rg == RG_CLK) clk_v[idx[CI_W-1:0]] <= wdata;
      if (data_wr && rg == RG_TMR) tmr_v[idx[TI_W-1:0]] <= wdata;
      if (xfer_up && sel_clk)   for (int i = 0; i < CLK_N; i++) clk_v[i] <= clk_h[i];
      if (xfer_up && sel_tmr)   for (int i = 0; i < TMR_N; i++) tmr_v[i] <= tmr_h[i];
      if (xfer_down && sel_clk) for (int i = 0; i < CLK_N; i++) clk_h[i] <= clk_v[i];
      if (xfer_down && sel_tmr) for (int i = 0; i < TMR_N; i++) tmr_h[i] <= tmr_v[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ALM_N; i++) alm_v[i] <= '0;
      for (int i = 0; i < USR_N; i++) usr_v[i] <= '0;
    end else begin
      if (data_wr && rg == RG_ALM) alm_v[idx[AI_W-1:0]] <= wdata;
      if (data_wr && rg == RG_USR) usr_v[idx[UI_W-1:0]] <= wdata;
    end
  end

  always_comb begin
    case (rg)
      RG_ST0:  rdata = st0;
      RG_ST1:  rdata = st1;
      RG_ST2:  rdata = st2;
      RG_TRIM: rdata = trim;
      RG_CLK:  rdata = clk_v[idx[CI_W-1:0]];
      RG_ALM:  rdata = alm_v[idx[AI_W-1:0]];
      RG_TMR:  rdata = tmr_v[idx[TI_W-1:0]];
      RG_USR:  rdata = usr_v[idx[UI_W-1:0]];
      default: rdata = '0;
    endcase
  end

  a_r7_lock_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && rg == RG_CMD && locked) |=> ($stable(clk_h[0]) && $stable(tmr_h[0])));
  a_r7_lock_trim: assert property (@(posedge clk) disable iff (!rst_n)
    trim_blocked |=> $stable(trim));
  a_r8_init_result: assert property (@(posedge clk) disable iff (!rst_n)
    init_fire |=> (st0 == ST0_AFTER_INIT && st1 == '0 && st2 == '0));
  a_r4_up_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_up && sel_clk) |=> (clk_v[CLK_N-1] == $past(clk_h[CLK_N-1])));
  a_r4_down_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_down && sel_tmr) |=> (tmr_h[0] == $past(tmr_v[0])));
endmodule

// File: rtl/rtcbus_host_if.sv
module rtcbus_host_if
  import rtcbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              bus_mode,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              ad_sel,
  input  logic [BYTE_W-1:0] ad_in,
  output logic [BYTE_W-1:0] ad_out,
  output logic              ad_oe
);
  logic rd_act, rd_pulse, wr_pulse;
  logic addr_load, data_wr, data_rd;
  logic [BYTE_W-1:0] addr_q, rdata;

  rtcbus_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .bus_mode(bus_mode),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .rd_act(rd_act), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse)
  );

  assign addr_load = wr_pulse && !ad_sel;
  assign data_wr   = wr_pulse && ad_sel;
  assign data_rd   = rd_pulse && ad_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (addr_load) addr_q <= ad_in;
  end

  rtcbus_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr_q),
    .data_wr(data_wr), .data_rd(data_rd), .wdata(ad_in), .rdata(rdata)
  );

  assign ad_oe  = rd_act;
  assign ad_out = !rd_act ? '0 : (ad_sel ? rdata : addr_q);

  a_r1_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> (addr_q == $past(ad_in)));
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_load |=> $stable(addr_q));
  a_r9_pf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |-> (!ad_oe && ad_out == '0));
  a_r10_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!cs_n && pwr_ok && !rd_n && wr_n));
endmodule

// File: tb/rtcbus_host_if_tb_top.sv
module rtcbus_host_if_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b1;
  logic bus_mode = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ad_sel = 1'b0;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] ad_out;
  logic ad_oe;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];
  event mon_ev;

  always #10 clk = ~clk;

  rtcbus_host_if dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .bus_mode(bus_mode),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .ad_sel(ad_sel),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results and compares with the bus
  initial forever begin
    @(mon_ev);
    while (exp_q.size() > 0) chk(tag_q.pop_front(), {ad_oe, ad_out}, exp_q.pop_front());
  end

  task automatic idle();
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic wr_cycle(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; ad_sel = sel; ad_in = d;
    if (bus_mode) begin rd_n = 1'b0; wr_n = 1'b0; end
    else wr_n = 1'b0;
    @(negedge clk);
    idle();
  endtask

  task automatic rd_check(input logic sel, input logic [7:0] e, input string tag);
    @(negedge clk);
    cs_n = 1'b0; ad_sel = sel; rd_n = 1'b0; wr_n = 1'b1;
    @(negedge clk);
    exp_q.push_back({1'b1, e});
    tag_q.push_back(tag);
    ->mon_ev;
    #1 idle();
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    wr_cycle(1'b0, a);
    wr_cycle(1'b1, d);
  endtask

  task automatic read_reg(input logic [7:0] a, input logic [7:0] e, input string tag);
    wr_cycle(1'b0, a);
    rd_check(1'b1, e, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle oe after reset", {ad_oe, ad_out}, 9'h000);
    rd_check(1'b0, 8'h00, "R2 pointer reset value");
    read_reg(8'h55, 8'h00, "R5 ram reset value");

    // R1 R2 R3
    write_reg(8'h53, 8'hA5);
    rd_check(1'b1, 8'hA5, "R1 data readback");
    rd_check(1'b0, 8'h53, "R2 pointer readback");
    wr_cycle(1'b1, 8'h3C);
    rd_check(1'b1, 8'h3C, "R3 pointer sticky");

    // R6 unmapped
    write_reg(8'h60, 8'hFF); rd_check(1'b1, 8'h00, "R6 unmapped 60");
    write_reg(8'h29, 8'hFF); rd_check(1'b1, 8'h00, "R6 unmapped 29");
    write_reg(8'h44, 8'hFF); rd_check(1'b1, 8'h00, "R6 unmapped 44");

    // R5 map
    write_reg(8'h10, 8'hD2); rd_check(1'b1, 8'hD2, "R5 trim");
    write_reg(8'h34, 8'h31); rd_check(1'b1, 8'h31, "R5 alarm");
    write_reg(8'h43, 8'h23); rd_check(1'b1, 8'h23, "R5 timer");
    write_reg(8'h00, 8'h10); rd_check(1'b1, 8'h10, "R5 status0");

    // R4 transfers
    for (int i = 0; i < 9; i++) write_reg(8'h20 + 8'(i), 8'h10 + 8'(i));
    for (int i = 0; i < 4; i++) write_reg(8'h40 + 8'(i), 8'h70 + 8'(i));
    write_reg(8'hF0, 8'hEE);
    write_reg(8'h20, 8'h00);
    write_reg(8'h40, 8'h00);
    wr_cycle(1'b0, 8'hF1);
    rd_check(1'b1, 8'h00, "R4 command read data");
    read_reg(8'h20, 8'h10, "R4 clock restored by F1");
    read_reg(8'h40, 8'h00, "R4 timer untouched by F1");
    wr_cycle(1'b0, 8'hF2);
    rd_check(1'b1, 8'h00, "R4 command read data F2");
    read_reg(8'h40, 8'h70, "R4 timer restored by F2");
    read_reg(8'h28, 8'h18, "R4 last clock byte");
    write_reg(8'h21, 8'h99);
    write_reg(8'hF1, 8'h00);
    write_reg(8'h21, 8'h00);
    write_reg(8'h41, 8'h55);
    wr_cycle(1'b0, 8'hF0);
    rd_check(1'b1, 8'h00, "R4 command read data F0");
    read_reg(8'h21, 8'h99, "R4 F1 write copied clock");
    read_reg(8'h41, 8'h71, "R4 F0 read copied timer");

    // R7 lock
    write_reg(8'h00, 8'h20);
    write_reg(8'h22, 8'hAA);
    write_reg(8'hF1, 8'h00);
    wr_cycle(1'b0, 8'hF1);
    rd_check(1'b1, 8'h00, "R7 read copy under lock");
    read_reg(8'h22, 8'h12, "R7 hidden kept under lock");
    write_reg(8'h10, 8'h11); rd_check(1'b1, 8'hD2, "R7 trim locked");
    write_reg(8'h5F, 8'h77); rd_check(1'b1, 8'h77, "R7 ram free under lock");

    // R8 init sequence
    write_reg(8'h01, 8'h05);
    write_reg(8'h02, 8'h00);
    read_reg(8'h01, 8'h05, "R8 no init without prior 1");
    write_reg(8'h02, 8'h10);
    write_reg(8'h02, 8'h00);
    read_reg(8'h00, 8'h01, "R8 status0 after init");
    read_reg(8'h01, 8'h00, "R8 status1 after init");
    read_reg(8'h02, 8'h00, "R8 status2 after init");
    write_reg(8'h10, 8'h91); rd_check(1'b1, 8'h91, "R8 lock released trim");

    // R9 power fail, R10 oe during write
    write_reg(8'h50, 8'h42);
    @(negedge clk);
    cs_n = 1'b0; ad_sel = 1'b1; wr_n = 1'b0; ad_in = 8'h00;
    @(negedge clk);
    chk("R10 no drive during write", {ad_oe, ad_out}, 9'h000);
    idle();
    write_reg(8'h50, 8'h42);
    pwr_ok = 1'b0;
    @(negedge clk);
    cs_n = 1'b0; ad_sel = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk("R9 no drive in power fail", {ad_oe, ad_out}, 9'h000);
    idle();
    wr_cycle(1'b1, 8'hEE);
    wr_cycle(1'b0, 8'h00);
    @(negedge clk);
    pwr_ok = 1'b1;
    rd_check(1'b1, 8'h42, "R9 data kept across power fail");
    rd_check(1'b0, 8'h50, "R9 pointer kept across power fail");

    // R12 one action per strobe
    write_reg(8'h52, 8'h00);
    @(negedge clk);
    cs_n = 1'b0; ad_sel = 1'b1; wr_n = 1'b0; ad_in = 8'h11;
    @(negedge clk);
    ad_in = 8'h22;
    @(negedge clk);
    idle();
    rd_check(1'b1, 8'h11, "R12 held strobe acts once");

    // R11 data strobe style
    bus_mode = 1'b1;
    write_reg(8'h51, 8'h6B);
    read_reg(8'h51, 8'h6B, "R11 strobe style 1 data");
    rd_check(1'b0, 8'h51, "R11 strobe style 1 pointer");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule